// File: doc/BRIEF.md
# Bidirectional Arithmetic Shifter with Condition Flags

This unit performs one arithmetic shift per cycle for a fixed-point signal-processing datapath. A 40-bit operand (8 guard bits above 32 data bits) is shifted by a signed 7-bit amount. A positive amount moves the bits toward the most significant end. A negative amount moves them toward the least significant end, filling with copies of bit 39. The shifted value is registered and appears on the result port in the cycle after the execute strobe.

Five condition bits are produced alongside the result: a selectable bit (DC), negative (N), zero (Z), overflow (V) and greater-than (GT). A 3-bit select input decides what DC reports. The flags are written only for unconditional operations. A conditional operation updates the result but leaves all five flags as they were. Instruction decode, operand fetch and evaluation of the condition lie outside this unit. The amount may come from a register or from an immediate, and the unit treats both the same way.

Top module: `ash_unit`

## Requirements
- R1: With amount in +1..+32 (7-bit two's complement), the result one cycle after exec_i is the operand shifted left by that amount, truncated to 40 bits, with zeros entering at bit 0.
- R2: With amount in -32..-1, the result is the operand shifted right by the magnitude, with bit 39 replicated into the vacated upper bits.
- R3: An amount of 0 returns the operand unchanged, and DC is 0 when the select field is 000.
- R4: With select 000 (carry mode), DC is the last bit shifted out: operand bit 40-k for a left shift by k, and operand bit k-1 for a right shift by k.
- R5: With select 001, DC equals result bit 39. With select 010, DC is 1 exactly when the whole 40-bit result is zero.
- R6: With select 011, 100, 101, 110 or 111, DC is 0.
- R7: N equals result bit 39, Z is 1 exactly when the result is zero, and V and GT are always 0.
- R8: An execution with cond_i=0 writes all five flags in the same cycle as the result. An execution with cond_i=1 writes the result and leaves every flag unchanged.
- R9: While exec_i is 0, the result and flags hold their values. res_vld_o is 1 exactly in the cycle after an execution.
- R10: After reset, the result, res_vld_o and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute strobe for one shift |
| cond_i | input | 1 | 1 = conditional operation (flags not written) |
| src_i | input | 40 | Operand to shift |
| amt_i | input | 7 | Signed shift amount, two's complement |
| cs_i | input | 3 | Selects the meaning of DC |
| res_o | output | 40 | Registered shift result |
| res_vld_o | output | 1 | Result written in the previous cycle |
| dc_o | output | 1 | Selectable condition bit |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| gt_o | output | 1 | Greater-than flag |

## Verification
The assertions check the register discipline on every cycle. The flags stay frozen across conditional executions and idle cycles, res_vld_o follows the strobe, N and Z agree with the result after each unconditional write, DC follows the negative and reserved selections, and a zero amount passes the operand through. The exact shifted values and the carry-mode DC bit at the edges of the range (amounts of ±1, ±32, a sign bit shifted out, a lone bit pushed off the low end) can be shown only by the bench's table of worked vectors. Amounts beyond ±32 are never checked.

// File: rtl/ash_pkg.sv
package ash_pkg;
  localparam int unsigned DATA_W = 40;
  localparam int unsigned AMT_W  = 7;
  localparam int unsigned CS_W   = 3;

  typedef enum logic [CS_W-1:0] {
    CS_CARRY = 3'd0,
    CS_NEG   = 3'd1,
    CS_ZERO  = 3'd2,
    CS_OVF   = 3'd3,
    CS_GT    = 3'd4,
    CS_GE    = 3'd5,
    CS_RSV6  = 3'd6,
    CS_RSV7  = 3'd7
  } cs_e;

  typedef struct packed {
    logic dc;
    logic n;
    logic z;
    logic v;
    logic gt;
  } flags_t;
endpackage

// File: rtl/ash_shift_core.sv
module ash_shift_core #(
  parameter int unsigned W  = ash_pkg::DATA_W,
  parameter int unsigned AW = ash_pkg::AMT_W
) (
  input  logic [W-1:0]  src_i,
  input  logic [AW-1:0] amt_i,
  output logic [W-1:0]  res_o,
  output logic          out_bit_o
);
  localparam int unsigned XW = 2 * W;

  logic          neg;
  logic [AW-1:0] mag;
  logic [XW-1:0] lext;
  logic signed [XW-1:0] rext;

  assign neg = amt_i[AW-1];
  assign mag = neg ? AW'(-amt_i) : amt_i;

  // Widened so the last bit out lands at a fixed position; zero amount yields 0.
  always_comb begin
    lext = {{W{1'b0}}, src_i} << mag;
    rext = $signed({src_i, {W{1'b0}}}) >>> mag;
    if (neg) begin
      res_o     = rext[XW-1:W];
      out_bit_o = rext[W-1];
    end else begin
      res_o     = lext[W-1:0];
      out_bit_o = lext[W];
    end
  end
endmodule

// File: rtl/ash_flag_gen.sv
module ash_flag_gen #(
  parameter int unsigned W = ash_pkg::DATA_W
) (
  input  logic [W-1:0]          res_i,
  input  logic                  out_bit_i,
  input  logic [2:0]            cs_i,
  output ash_pkg::flags_t       flags_o
);
  import ash_pkg::*;

  logic is_neg, is_zero;

  assign is_neg  = res_i[W-1];
  assign is_zero = ~|res_i;

  always_comb begin
    flags_o.n  = is_neg;
    flags_o.z  = is_zero;
    flags_o.v  = 1'b0;
    flags_o.gt = 1'b0;
    unique case (cs_e'(cs_i))
      CS_CARRY: flags_o.dc = out_bit_i;
      CS_NEG:   flags_o.dc = is_neg;
      CS_ZERO:  flags_o.dc = is_zero;
      default:  flags_o.dc = 1'b0;
    endcase
  end
endmodule

// File: rtl/ash_unit.sv
module ash_unit #(
  parameter int unsigned W  = ash_pkg::DATA_W,
  parameter int unsigned AW = ash_pkg::AMT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          exec_i,
  input  logic          cond_i,
  input  logic [W-1:0]  src_i,
  input  logic [AW-1:0] amt_i,
  input  logic [2:0]    cs_i,
  output logic [W-1:0]  res_o,
  output logic          res_vld_o,
  output logic          dc_o,
  output logic          n_o,
  output logic          z_o,
  output logic          v_o,
  output logic          gt_o
);
  import ash_pkg::*;

  logic [W-1:0] sh_res;
  logic         sh_out;
  flags_t       flags_d, flags_q;
  logic [W-1:0] res_q;
  logic         vld_q;

  ash_shift_core #(.W(W), .AW(AW)) i_core (
    .src_i     (src_i),
    .amt_i     (amt_i),
    .res_o     (sh_res),
    .out_bit_o (sh_out)
  );

  ash_flag_gen #(.W(W)) i_flags (
    .res_i     (sh_res),
    .out_bit_i (sh_out),
    .cs_i      (cs_i),
    .flags_o   (flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= exec_i;
      if (exec_i) res_q <= sh_res;
    end
  end

  // Conditional forms never touch the status bits.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               flags_q <= '0;
    else if (exec_i && !cond_i) flags_q <= flags_d;
  end

  assign res_o     = res_q;
  assign res_vld_o = vld_q;
  assign dc_o      = flags_q.dc;
  assign n_o       = flags_q.n;
  assign z_o       = flags_q.z;
  assign v_o       = flags_q.v;
  assign gt_o      = flags_q.gt;
endmodule

// File: rtl/ash_unit_chk.sv
module ash_unit_chk #(
  parameter int unsigned W  = 40,
  parameter int unsigned AW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          exec_i,
  input logic          cond_i,
  input logic [W-1:0]  src_i,
  input logic [AW-1:0] amt_i,
  input logic [2:0]    cs_i,
  input logic [W-1:0]  res_o,
  input logic          res_vld_o,
  input logic          dc_o,
  input logic          n_o,
  input logic          z_o,
  input logic          v_o,
  input logic          gt_o
);
  logic [4:0] flg;
  assign flg = {dc_o, n_o, z_o, v_o, gt_o};

  AST_COND_FLAGS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && cond_i |=> $stable(flg)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> $stable(flg) && $stable(res_o)); // R9
  AST_VLD_AFTER_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i |=> res_vld_o); // R9
  AST_VLD_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> !res_vld_o); // R9
  AST_NZ_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && !cond_i |=> (n_o == res_o[W-1]) && (z_o == (res_o == '0)) && !v_o && !gt_o); // R7
  AST_DC_NEG_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && !cond_i && cs_i == 3'd1 |=> dc_o == res_o[W-1]); // R5
  AST_DC_RSV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && !cond_i && cs_i >= 3'd3 |=> !dc_o); // R6
  AST_ZERO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && amt_i == '0 |=> res_o == $past(src_i)); // R3
endmodule

bind ash_unit ash_unit_chk #(.W(W), .AW(AW)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .exec_i    (exec_i),
  .cond_i    (cond_i),
  .src_i     (src_i),
  .amt_i     (amt_i),
  .cs_i      (cs_i),
  .res_o     (res_o),
  .res_vld_o (res_vld_o),
  .dc_o      (dc_o),
  .n_o       (n_o),
  .z_o       (z_o),
  .v_o       (v_o),
  .gt_o      (gt_o)
);

// File: tb/test_ash_unit.sv
module test_ash_unit;
  localparam int unsigned W  = 40;
  localparam int unsigned AW = 7;
  localparam int unsigned NV = 14;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          exec_i = 1'b0;
  logic          cond_i = 1'b0;
  logic [W-1:0]  src_i = '0;
  logic [AW-1:0] amt_i = '0;
  logic [2:0]    cs_i = '0;
  logic [W-1:0]  res_o;
  logic          res_vld_o, dc_o, n_o, z_o, v_o, gt_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ash_unit i_ash_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .exec_i(exec_i), .cond_i(cond_i),
    .src_i(src_i), .amt_i(amt_i), .cs_i(cs_i), .res_o(res_o),
    .res_vld_o(res_vld_o), .dc_o(dc_o), .n_o(n_o), .z_o(z_o),
    .v_o(v_o), .gt_o(gt_o)
  );

  // {src, amt, cs, expected result, expected dc}
  localparam logic [90:0] VECS [NV] = '{
    {40'h00_0000_0001, 7'h04, 3'd0, 40'h00_0000_0010, 1'b0}, // R1
    {40'h80_0000_0000, 7'h01, 3'd0, 40'h00_0000_0000, 1'b1}, // R4
    {40'h00_8000_0000, 7'h08, 3'd1, 40'h80_0000_0000, 1'b1}, // R5
    {40'hFF_FFFF_FF00, 7'h7C, 3'd0, 40'hFF_FFFF_FFF0, 1'b0}, // R2
    {40'h00_0000_0008, 7'h7C, 3'd0, 40'h00_0000_0000, 1'b1}, // R4
    {40'h80_0000_0000, 7'h60, 3'd1, 40'hFF_FFFF_FF80, 1'b1}, // R2
    {40'h12_3456_789A, 7'h00, 3'd0, 40'h12_3456_789A, 1'b0}, // R3
    {40'h00_0000_0001, 7'h20, 3'd2, 40'h01_0000_0000, 1'b0}, // R1
    {40'h00_0000_0001, 7'h7F, 3'd2, 40'h00_0000_0000, 1'b1}, // R5
    {40'h80_0000_0001, 7'h7F, 3'd3, 40'hC0_0000_0000, 1'b0}, // R6
    {40'h80_0000_0001, 7'h7F, 3'd4, 40'hC0_0000_0000, 1'b0}, // R6
    {40'h80_0000_0001, 7'h7F, 3'd5, 40'hC0_0000_0000, 1'b0}, // R6
    {40'h80_0000_0001, 7'h7F, 3'd7, 40'hC0_0000_0000, 1'b0}, // R6
    {40'hAA_AAAA_AAAA, 7'h1F, 3'd0, 40'h55_0000_0000, 1'b1}  // R4
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] s, input logic [AW-1:0] a,
                       input logic [2:0] c, input logic cnd);
    @(negedge clk_i);
    src_i = s; amt_i = a; cs_i = c; cond_i = cnd; exec_i = 1'b1;
    @(negedge clk_i);
    exec_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10 result", res_o, '0);
    chk("R10 flags", {35'd0, res_vld_o, dc_o, n_o, z_o, v_o, gt_o}, '0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [W-1:0] er;
      er = VECS[i][40:1];
      apply(VECS[i][90:51], VECS[i][50:44], VECS[i][43:41], 1'b0);
      chk("R1/R2/R3 result", res_o, er);
      chk("R4/R5/R6 dc", {39'd0, dc_o}, {39'd0, VECS[i][0]});
      chk("R7 n,z,v,gt", {36'd0, n_o, z_o, v_o, gt_o},
          {36'd0, er[W-1], er == '0, 1'b0, 1'b0});
      chk("R9 vld", {39'd0, res_vld_o}, 40'd1);
    end

    // R8: set known flags, then a conditional op that would change them
    apply(40'h80_0000_0000, 7'h01, 3'd0, 1'b0); // res 0, dc=1, z=1
    apply(40'h80_0000_0000, 7'h7C, 3'd2, 1'b1); // res F8_0000_0000
    chk("R8 cond result", res_o, 40'hF8_0000_0000);
    chk("R8 cond flags kept", {35'd0, dc_o, n_o, z_o, v_o, gt_o},
        {35'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0});
    apply(40'h00_0000_0003, 7'h7E, 3'd0, 1'b0); // res 0, dc = src[1]=1
    chk("R8 uncond result", res_o, 40'h0);
    chk("R8 uncond flags", {35'd0, dc_o, n_o, z_o, v_o, gt_o},
        {35'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0});
    apply(40'hFF_0000_0000, 7'h02, 3'd1, 1'b0); // res FC_0000_0000
    chk("R8 uncond flags 2", {35'd0, dc_o, n_o, z_o, v_o, gt_o},
        {35'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});

    // R9: inputs change without exec
    @(negedge clk_i);
    src_i = 40'h0; amt_i = 7'h00; cs_i = 3'd2; cond_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R9 idle result", res_o, 40'hFC_0000_0000);
    chk("R9 idle flags", {35'd0, dc_o, n_o, z_o, v_o, gt_o},
        {35'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
    chk("R9 idle vld", {39'd0, res_vld_o}, 40'd0);

    // R10: asynchronous reset mid-run
    #1 rst_ni = 1'b0;
    #1 chk("R10 async result", res_o, '0);
    chk("R10 async flags", {35'd0, res_vld_o, dc_o, n_o, z_o, v_o, gt_o}, '0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule